// File: doc/BRIEF.md
# Link Power Status Interface Controller

This block sits between a PHY core and the link-layer controller attached to it, and decides from one power-status line driven by the link whether the PHY-to-link interface is live. A saturating counter measures how many consecutive clock samples the status line has been low. Both time limits, about 2.6 µs and about 26 µs, are converted to cycle counts from a clock-frequency parameter. When the shorter limit is exceeded the interface drops into a low-power reset. When the longer limit is exceeded it drops into a disabled state that also stops the system clock.

In normal operation the control bus, the data bus and the link request are passed straight through between the PHY core and the link. In the reset state the two buses are forced to zero and link requests are dropped, but the system clock keeps running. The disabled state additionally clears the clock enable, and hardware reset holds the interface disabled. A high sample on the status line wakes the interface. It first passes through a fixed-length initialisation phase with its outputs still at zero, and then returns to normal, marking that moment with a one-cycle done pulse. The interface state depends on the status line alone.

Top module: `lps_link_ctrl`

## Requirements
- R1: When hardware reset is released with the status line low, the interface reports state code 2 (disabled), with `sysClkEn` at 0 and `ctlOut`, `dataOut` and `lreqOut` all at zero.
- R2: A low period on `lpsIn` of at most RESET_CYC consecutive samples leaves the state at 0 (normal). RESET_CYC is CLK_FREQ_HZ·26/10^7, which is 260 at 100 MHz. When the line is still low at the edge after sample RESET_CYC+1, the state becomes 1 (reset).
- R3: In state 1, `ctlOut` and `dataOut` are zero and `lreqOut` is 0 whatever `ctlIn`, `dataIn` and `lreqIn` carry, while `sysClkEn` stays 1.
- R4: When the line is still low at the edge after sample DISABLE_CYC+1, the state becomes 2 (disabled) and `sysClkEn` goes to 0. DISABLE_CYC is CLK_FREQ_HZ·26/10^6, which is 2600 at 100 MHz.
- R5: Asserting `rstN` low forces state 2 at once and holds it for as long as reset is held, even with `lpsIn` high.
- R6: A high sample of `lpsIn` in state 1 or state 2 moves the interface to state 3 (init) at that edge. State 3 lasts exactly INIT_CYC cycles (default 4), with the buses zero and `sysClkEn` at 1, and is followed by state 0.
- R7: `initDone` is 1 during exactly the first cycle of state 0 after state 3, and 0 at all other times.
- R8: In state 0, `ctlOut` equals `ctlIn`, `dataOut` equals `dataIn`, `lreqOut` equals `lreqIn`, and `sysClkEn` is 1.
- R9: The low-duration count restarts on every high sample. Two low runs of 200 samples separated by a single high sample leave the state at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rstN | input | 1 | Asynchronous hardware reset, active low |
| lpsIn | input | 1 | Link power-status line from the link controller |
| lreqIn | input | 1 | Link request from the link controller |
| ctlIn | input | CTL_W | Control value the PHY core wants to present |
| dataIn | input | DATA_W | Data value the PHY core wants to present |
| ctlOut | output | CTL_W | Control bus toward the link |
| dataOut | output | DATA_W | Data bus toward the link |
| lreqOut | output | 1 | Link request forwarded to the PHY core |
| sysClkEn | output | 1 | System clock output enable |
| ifState | output | 2 | 0 normal, 1 reset, 2 disabled, 3 init |
| initDone | output | 1 | One-cycle pulse when initialisation completes |

## Verification
Low pulses of increasing length are applied on both sides of each threshold: 260 against 261 samples separates normal from reset, and 2600 against 2601 separates reset from disabled. Every pulse that leaves the normal state is followed by a wake-up, which checks the length of the init phase and the timing of the done pulse. A split low run, 200 samples, then one high sample, then 200 more, shows whether the count restarts or accumulates. Asserting reset while the line is high shows that hardware reset overrides the status input.

// File: rtl/lps_pkg.sv
package lps_pkg;

  typedef enum logic [1:0] {
    IF_NORMAL   = 2'd0,
    IF_RESET    = 2'd1,
    IF_DISABLED = 2'd2,
    IF_INIT     = 2'd3
  } ifState_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic passThru;   // buses and request follow their sources
    logic clkEn;      // system clock output enabled
    logic initRun;    // initialisation counter running
  } ctrlStrobe_t;

endpackage

// File: rtl/lps_datapath.sv
module lps_datapath
  import lps_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 100_000_000,
  parameter int unsigned CTL_W       = 2,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned INIT_CYC    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lpsIn,
  input  logic              lreqIn,
  input  logic [CTL_W-1:0]  ctlIn,
  input  logic [DATA_W-1:0] dataIn,
  input  ctrlStrobe_t       stb,
  output logic              overReset,
  output logic              overDisable,
  output logic              initLast,
  output logic [CTL_W-1:0]  ctlOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              lreqOut,
  output logic              sysClkEn
);

  // Thresholds in clock cycles: 2.6 us and 26 us
  localparam longint unsigned RESET_CYC   = (longint'(CLK_FREQ_HZ) * 26) / 10_000_000;
  localparam longint unsigned DISABLE_CYC = (longint'(CLK_FREQ_HZ) * 26) / 1_000_000;
  localparam int unsigned CNT_W  = $clog2(DISABLE_CYC + 2);
  localparam int unsigned INIT_W = (INIT_CYC < 2) ? 1 : $clog2(INIT_CYC);
  localparam logic [CNT_W-1:0]  RESET_LIM   = CNT_W'(RESET_CYC);
  localparam logic [CNT_W-1:0]  DISABLE_LIM = CNT_W'(DISABLE_CYC);
  localparam logic [CNT_W-1:0]  CNT_SAT     = CNT_W'(DISABLE_CYC + 1);
  localparam logic [INIT_W-1:0] INIT_END    = INIT_W'(INIT_CYC - 1);

  logic [CNT_W-1:0]  lowCnt;
  logic [INIT_W-1:0] initCnt;

  // Consecutive-low counter, restarted by any high sample, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
    end else if (lpsIn) begin
      lowCnt <= '0;
    end else if (lowCnt != CNT_SAT) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  assign overReset   = (lowCnt > RESET_LIM);
  assign overDisable = (lowCnt > DISABLE_LIM);

  // Initialisation phase length counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initCnt <= '0;
    end else if (!stb.initRun) begin
      initCnt <= '0;
    end else if (initCnt != INIT_END) begin
      initCnt <= initCnt + 1'b1;
    end
  end

  assign initLast = stb.initRun && (initCnt == INIT_END);

  // Output gating toward the link
  assign ctlOut   = stb.passThru ? ctlIn  : '0;
  assign dataOut  = stb.passThru ? dataIn : '0;
  assign lreqOut  = stb.passThru & lreqIn;
  assign sysClkEn = stb.clkEn;

  AST_OVER_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    overReset |-> !$past(lpsIn)); // R2

  AST_HIGH_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    lpsIn |=> !overReset); // R9

  AST_DISABLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rstN)
    overDisable |-> overReset && $past(overReset)); // R4

endmodule

// File: rtl/lps_ctrl.sv
module lps_ctrl
  import lps_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        lpsIn,
  input  logic        overReset,
  input  logic        overDisable,
  input  logic        initLast,
  output ctrlStrobe_t stb,
  output ifState_e    state,
  output logic        initDone
);

  ifState_e stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      IF_NORMAL:   if (overReset) stateNext = IF_RESET;
      IF_RESET: begin
        if (lpsIn)            stateNext = IF_INIT;
        else if (overDisable) stateNext = IF_DISABLED;
      end
      IF_DISABLED: if (lpsIn) stateNext = IF_INIT;
      IF_INIT:     if (initLast) stateNext = IF_NORMAL;
      default:     stateNext = IF_DISABLED;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= IF_DISABLED;
      initDone <= 1'b0;
    end else begin
      state    <= stateNext;
      initDone <= (state == IF_INIT) && initLast;
    end
  end

  always_comb begin
    stb.passThru = (state == IF_NORMAL);
    stb.clkEn    = (state != IF_DISABLED);
    stb.initRun  = (state == IF_INIT);
  end

  AST_ENTER_RESET: assert property (@(posedge clk) disable iff (!rstN)
    (state == IF_NORMAL) && overReset |=> state == IF_RESET); // R2

  AST_ENTER_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (state == IF_RESET) && !lpsIn && overDisable |=> state == IF_DISABLED); // R4

  AST_WAKE_TO_INIT: assert property (@(posedge clk) disable iff (!rstN)
    ((state == IF_RESET) || (state == IF_DISABLED)) && lpsIn |=> state == IF_INIT); // R6

  AST_DONE_AFTER_INIT: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> (state == IF_NORMAL) && ($past(state) == IF_INIT)); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> !initDone); // R7

endmodule

// File: rtl/lps_link_ctrl.sv
module lps_link_ctrl
  import lps_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 100_000_000,
  parameter int unsigned CTL_W       = 2,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned INIT_CYC    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lpsIn,
  input  logic              lreqIn,
  input  logic [CTL_W-1:0]  ctlIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [CTL_W-1:0]  ctlOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              lreqOut,
  output logic              sysClkEn,
  output logic [1:0]        ifState,
  output logic              initDone
);

  ctrlStrobe_t stb;
  ifState_e    state;
  logic        overReset;
  logic        overDisable;
  logic        initLast;

  lps_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .lpsIn       (lpsIn),
    .overReset   (overReset),
    .overDisable (overDisable),
    .initLast    (initLast),
    .stb         (stb),
    .state       (state),
    .initDone    (initDone)
  );

  lps_datapath #(
    .CLK_FREQ_HZ (CLK_FREQ_HZ),
    .CTL_W       (CTL_W),
    .DATA_W      (DATA_W),
    .INIT_CYC    (INIT_CYC)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .lpsIn       (lpsIn),
    .lreqIn      (lreqIn),
    .ctlIn       (ctlIn),
    .dataIn      (dataIn),
    .stb         (stb),
    .overReset   (overReset),
    .overDisable (overDisable),
    .initLast    (initLast),
    .ctlOut      (ctlOut),
    .dataOut     (dataOut),
    .lreqOut     (lreqOut),
    .sysClkEn    (sysClkEn)
  );

  assign ifState = state;

endmodule

// File: tb/lps_link_ctrl_test.sv
module lps_link_ctrl_test;

  localparam int INIT_CYC = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lpsIn = 1'b0;
  logic       lreqIn = 1'b0;
  logic [1:0] ctlIn = '0;
  logic [7:0] dataIn = '0;
  logic [1:0] ctlOut;
  logic [7:0] dataOut;
  logic       lreqOut;
  logic       sysClkEn;
  logic [1:0] ifState;
  logic       initDone;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lps_link_ctrl uut (
    .clk(clk), .rstN(rstN), .lpsIn(lpsIn), .lreqIn(lreqIn),
    .ctlIn(ctlIn), .dataIn(dataIn), .ctlOut(ctlOut), .dataOut(dataOut),
    .lreqOut(lreqOut), .sysClkEn(sysClkEn), .ifState(ifState), .initDone(initDone)
  );

  // Low length, expected state: normal up to 260, reset up to 2600, disabled beyond
  localparam int NVEC = 10;
  localparam int VEC_LEN [NVEC] = '{1, 100, 260, 261, 262, 1000, 2600, 2601, 3000, 5};
  localparam int VEC_EXP [NVEC] = '{0, 0, 0, 1, 1, 1, 1, 2, 2, 0};

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic wake_and_check(input string req);
    lpsIn = 1'b1;
    step(1);
    chk({req, " R6 init entered"}, ifState, 3);
    chk({req, " R6 init clock on"}, sysClkEn, 1);
    chk({req, " R6 init data zero"}, dataOut, 0);
    chk({req, " R7 no early done"}, initDone, 0);
    step(INIT_CYC - 1);
    chk({req, " R6 init last cycle"}, ifState, 3);
    step(1);
    chk({req, " R6 back to normal"}, ifState, 0);
    chk({req, " R7 done pulse"}, initDone, 1);
    step(1);
    chk({req, " R7 done cleared"}, initDone, 0);
  endtask

  initial begin
    #2_000_000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state with line low
    ctlIn = 2'b11; dataIn = 8'hA5; lreqIn = 1'b1;
    step(3);
    rstN = 1'b1;
    step(3);
    chk("R1 state disabled", ifState, 2);
    chk("R1 clock off", sysClkEn, 0);
    chk("R1 ctl zero", ctlOut, 0);
    chk("R1 data zero", dataOut, 0);
    chk("R1 lreq zero", lreqOut, 0);
    wake_and_check("R1");

    // Table walk over the thresholds
    for (int v = 0; v < NVEC; v++) begin
      ctlIn = 2'(v + 1); dataIn = 8'(8'h3C ^ v); lreqIn = 1'b1;
      lpsIn = 1'b0;
      step(VEC_LEN[v] + 1);
      chk($sformatf("R2 R4 state after %0d low", VEC_LEN[v]), ifState, VEC_EXP[v]);
      if (VEC_EXP[v] == 1) begin
        chk("R3 ctl zero", ctlOut, 0);
        chk("R3 data zero", dataOut, 0);
        chk("R3 lreq ignored", lreqOut, 0);
        chk("R3 clock on", sysClkEn, 1);
      end else if (VEC_EXP[v] == 2) begin
        chk("R4 clock off", sysClkEn, 0);
        chk("R4 data zero", dataOut, 0);
      end else begin
        chk("R8 ctl passes", ctlOut, ctlIn);
        chk("R8 data passes", dataOut, dataIn);
        chk("R8 lreq passes", lreqOut, 1);
      end
      if (VEC_EXP[v] != 0) begin
        wake_and_check("R6");
      end else begin
        lpsIn = 1'b1;
        step(1);
      end
    end

    // R8: pass-through patterns in normal
    lpsIn = 1'b1;
    ctlIn = 2'b10; dataIn = 8'h5A; lreqIn = 1'b0;
    step(1);
    chk("R8 ctl 2", ctlOut, 2);
    chk("R8 data 5A", dataOut, 8'h5A);
    chk("R8 lreq 0", lreqOut, 0);
    chk("R8 clock on", sysClkEn, 1);

    // R9: split low run does not accumulate
    lpsIn = 1'b0; step(200);
    lpsIn = 1'b1; step(1);
    lpsIn = 1'b0; step(200);
    chk("R9 split run stays normal", ifState, 0);
    lpsIn = 1'b1; step(2);
    chk("R9 still normal", ifState, 0);

    // R5: hardware reset overrides a high line
    rstN = 1'b0;
    #1;
    chk("R5 immediate disabled", ifState, 2);
    chk("R5 clock off", sysClkEn, 0);
    step(5);
    chk("R5 held disabled", ifState, 2);
    chk("R5 data zero", dataOut, 0);
    rstN = 1'b1;
    step(1);
    chk("R5 R6 wake after release", ifState, 3);
    step(INIT_CYC);
    chk("R6 normal after release", ifState, 0);
    chk("R7 done after release", initDone, 1);

    finish_run();
  end

endmodule